// File: doc/BRIEF.md
# Operand Bypass Select Network

This block resolves read-after-write dependences for the two ALU operands of a five-stage in-order pipeline without costing a cycle. In the decode stage it takes the two source specifiers and the values the register file returns for them. When the write-back stage is writing one of those registers in the same cycle, the block substitutes the value being written. The corrected values and their specifiers are captured in an execute-stage operand slice.

In the execute stage, each operand picks one of three sources: the captured register-file value, the ALU result held by the memory-stage instruction, or the value being written back. The nearest producer wins. Register 0 is never forwarded. A memory-stage instruction that is a load has no data yet, so the block does not forward from it. Stall generation and the register file are outside the block. The selects are output so the datapath and debug logic can see them.

Top module: `fwd_bypass_net`

## Requirements
- R1: With no matching producer, each operand select is 2'b00 and the operand equals the register-file value captured from decode on the previous clock edge. Select codes: 2'b00 register file, 2'b01 write-back value, 2'b10 memory-stage ALU result. The code 2'b11 never appears.
- R2: When the memory-stage write enable is high, the memory instruction is not a load, its destination is non-zero and equals an operand's captured source, that operand's select is 2'b10 and the operand equals `mem_alu_res`.
- R3: When only the write-back stage matches (enable high, destination non-zero and equal to the source), the select is 2'b01 and the operand equals `wb_data`.
- R4: When both stages match the same source, the memory-stage value wins and the select is 2'b10.
- R5: A source or destination of register 0 is never forwarded, even with the write enables high. The select stays 2'b00.
- R6: A stage whose write enable is low never forwards, even if its destination matches.
- R7: A memory-stage load (`mem_is_load` high) is never forwarded. The operand falls back to a matching write-back value (2'b01), otherwise to the register file (2'b00).
- R8: If the write-back stage writes a non-zero register in the same cycle decode reads it, the captured operand is `wb_data` and not the stale register-file value. A write to register 0 never replaces the read value.
- R9: The two operands are resolved independently, each with its own select.
- R10: While `rst_n` is low, the captured specifiers and values are zero, so both selects are 2'b00 and both operands are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| id_rs1_addr | input | AW | Decode-stage first source specifier |
| id_rs2_addr | input | AW | Decode-stage second source specifier |
| id_rf_rd1 | input | DW | Register-file read data for the first source |
| id_rf_rd2 | input | DW | Register-file read data for the second source |
| mem_rd_addr | input | AW | Memory-stage destination specifier |
| mem_wen | input | 1 | Memory-stage register write enable |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_res | input | DW | ALU result held in the memory-stage register |
| wb_rd_addr | input | AW | Write-back destination specifier |
| wb_wen | input | 1 | Write-back register write enable |
| wb_data | input | DW | Value being written back |
| ex_sel_a | output | 2 | First operand select |
| ex_sel_b | output | 2 | Second operand select |
| ex_opnd_a | output | DW | First resolved operand |
| ex_opnd_b | output | DW | Second resolved operand |

## Verification
Directed patterns place the execute-stage sources against memory and write-back destinations: no match, a match in one stage only, a match in both stages, matches with the enable low, and matches on register 0. A double write to one register shows whether priority goes to the nearest producer. Each operand is given a different pattern, so a select crossed between operands or shared by them shows up. A load in the memory stage over a matching write-back separates "skip the load" from "fall back to the register file". Same-cycle decode reads against write-back writes, to a live register and to register 0, test the write-through path on its own.

// File: rtl/fwd_bypass_pkg.sv
package fwd_bypass_pkg;
  localparam int NUM_OPND = 2;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/fwd_wt_bypass.sv
// Same-cycle write-through: a decode read of the register being written
// back returns the new value. Register 0 is excluded.
module fwd_wt_bypass #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rf_data,
  input  logic [AW-1:0] wb_addr,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] rd_value
);
  logic hit;

  always_comb begin
    hit      = wb_wen && (wb_addr != '0) && (wb_addr == rd_addr);
    rd_value = hit ? wb_data : rf_data;
  end
endmodule

// File: rtl/fwd_pick.sv
// Per-operand priority select: memory stage first, then write-back,
// then the captured register-file value.
module fwd_pick
  import fwd_bypass_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_rf,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  input  logic [DW-1:0] mem_res,
  input  logic [AW-1:0] wb_addr,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [1:0]    sel,
  output logic [DW-1:0] opnd
);
  logic      mem_hit;
  logic      wb_hit;
  opnd_src_e src;

  always_comb begin
    mem_hit = mem_wen && !mem_is_load && (mem_addr != '0) && (mem_addr == src_addr);
    wb_hit  = wb_wen && (wb_addr != '0) && (wb_addr == src_addr);
    if (mem_hit) begin
      src  = SRC_MEM;
      opnd = mem_res;
    end else if (wb_hit) begin
      src  = SRC_WB;
      opnd = wb_data;
    end else begin
      src  = SRC_RF;
      opnd = src_rf;
    end
    sel = src;
  end
endmodule

// File: rtl/fwd_bypass_net.sv
module fwd_bypass_net
  import fwd_bypass_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1_addr,
  input  logic [AW-1:0] id_rs2_addr,
  input  logic [DW-1:0] id_rf_rd1,
  input  logic [DW-1:0] id_rf_rd2,
  input  logic [AW-1:0] mem_rd_addr,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  input  logic [DW-1:0] mem_alu_res,
  input  logic [AW-1:0] wb_rd_addr,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic [DW-1:0] ex_opnd_a,
  output logic [DW-1:0] ex_opnd_b
);
  logic [AW-1:0] id_addr   [NUM_OPND];
  logic [DW-1:0] id_raw    [NUM_OPND];
  logic [DW-1:0] id_fixed  [NUM_OPND];
  logic [AW-1:0] ex_addr_d [NUM_OPND];
  logic [DW-1:0] ex_data_d [NUM_OPND];
  logic [AW-1:0] ex_addr_q [NUM_OPND];
  logic [DW-1:0] ex_data_q [NUM_OPND];
  logic [1:0]    sel       [NUM_OPND];
  logic [DW-1:0] opnd      [NUM_OPND];

  always_comb begin
    id_addr[0] = id_rs1_addr;
    id_addr[1] = id_rs2_addr;
    id_raw[0]  = id_rf_rd1;
    id_raw[1]  = id_rf_rd2;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_wt_bypass #(.AW(AW), .DW(DW)) u_wt (
      .rd_addr  (id_addr[g]),
      .rf_data  (id_raw[g]),
      .wb_addr  (wb_rd_addr),
      .wb_wen   (wb_wen),
      .wb_data  (wb_data),
      .rd_value (id_fixed[g])
    );

    // next state of the execute-stage operand slice
    always_comb begin
      ex_addr_d[g] = id_addr[g];
      ex_data_d[g] = id_fixed[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ex_addr_q[g] <= '0;
        ex_data_q[g] <= '0;
      end else begin
        ex_addr_q[g] <= ex_addr_d[g];
        ex_data_q[g] <= ex_data_d[g];
      end
    end

    fwd_pick #(.AW(AW), .DW(DW)) u_pick (
      .src_addr    (ex_addr_q[g]),
      .src_rf      (ex_data_q[g]),
      .mem_addr    (mem_rd_addr),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .mem_res     (mem_alu_res),
      .wb_addr     (wb_rd_addr),
      .wb_wen      (wb_wen),
      .wb_data     (wb_data),
      .sel         (sel[g]),
      .opnd        (opnd[g])
    );
  end

  always_comb begin
    ex_sel_a  = sel[0];
    ex_sel_b  = sel[1];
    ex_opnd_a = opnd[0];
    ex_opnd_b = opnd[1];
  end
endmodule

// File: rtl/fwd_bypass_chk.sv
module fwd_bypass_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs1_addr,
  input logic [AW-1:0] id_rs2_addr,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_wen,
  input logic          mem_is_load,
  input logic [AW-1:0] wb_rd_addr,
  input logic          wb_wen,
  input logic [DW-1:0] wb_data,
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [DW-1:0] ex_val_a,
  input logic [DW-1:0] ex_val_b,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b
);
  AST_SEL_A_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_a)); // R1
  AST_SEL_B_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_b)); // R1
  AST_WB_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && wb_wen && wb_rd_addr != '0 && wb_rd_addr == ex_src_b) |-> sel_b == 2'b01); // R3
  AST_MEM_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_is_load && mem_rd_addr != '0 && mem_rd_addr == ex_src_a &&
     wb_wen && wb_rd_addr == ex_src_a) |-> sel_a == 2'b10); // R4
  AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0) |-> sel_a == 2'b00); // R5
  AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_b == '0) |-> sel_b == 2'b00); // R5
  AST_WEN_OFF_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && !wb_wen) |-> sel_a == 2'b00); // R6
  AST_LOAD_NOMEM_A: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_load |-> sel_a != 2'b10); // R7
  AST_LOAD_NOMEM_B: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_load |-> sel_b != 2'b10); // R7
  AST_WT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_rd_addr != '0 && wb_rd_addr == id_rs1_addr) |=> ex_val_a == $past(wb_data)); // R8
  AST_WT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_rd_addr != '0 && wb_rd_addr == id_rs2_addr) |=> ex_val_b == $past(wb_data)); // R8
endmodule

bind fwd_bypass_net fwd_bypass_chk #(.AW(AW), .DW(DW)) u_fwd_bypass_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_rs1_addr (id_rs1_addr),
  .id_rs2_addr (id_rs2_addr),
  .mem_rd_addr (mem_rd_addr),
  .mem_wen     (mem_wen),
  .mem_is_load (mem_is_load),
  .wb_rd_addr  (wb_rd_addr),
  .wb_wen      (wb_wen),
  .wb_data     (wb_data),
  .ex_src_a    (ex_addr_q[0]),
  .ex_src_b    (ex_addr_q[1]),
  .ex_val_a    (ex_data_q[0]),
  .ex_val_b    (ex_data_q[1]),
  .sel_a       (ex_sel_a),
  .sel_b       (ex_sel_b)
);

// File: tb/test_fwd_bypass_net.sv
module test_fwd_bypass_net;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] id_rs1_addr, id_rs2_addr, mem_rd_addr, wb_rd_addr;
  logic [DW-1:0] id_rf_rd1, id_rf_rd2, mem_alu_res, wb_data;
  logic          mem_wen, mem_is_load, wb_wen;
  logic [1:0]    ex_sel_a, ex_sel_b;
  logic [DW-1:0] ex_opnd_a, ex_opnd_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fwd_bypass_net #(.AW(AW), .DW(DW)) i_fwd_bypass_net (
    .clk, .rst_n, .id_rs1_addr, .id_rs2_addr, .id_rf_rd1, .id_rf_rd2,
    .mem_rd_addr, .mem_wen, .mem_is_load, .mem_alu_res,
    .wb_rd_addr, .wb_wen, .wb_data,
    .ex_sel_a, .ex_sel_b, .ex_opnd_a, .ex_opnd_b
  );

  task automatic check(input string req, input logic [1:0] sel, input logic [DW-1:0] val,
                       input logic [1:0] exp_sel, input logic [DW-1:0] exp_val);
    checks++;
    if (sel !== exp_sel || val !== exp_val) begin
      errors++;
      $display("FAIL %s: sel=%b val=%h expected sel=%b val=%h", req, sel, val, exp_sel, exp_val);
    end
  endtask

  task automatic later_off();
    mem_wen = 0; mem_is_load = 0; mem_rd_addr = '0; mem_alu_res = '0;
    wb_wen = 0; wb_rd_addr = '0; wb_data = '0;
  endtask

  // capture decode operands into the execute slice, with write-back idle
  task automatic load_ex(input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                         input logic [AW-1:0] a2, input logic [DW-1:0] d2);
    @(negedge clk);
    later_off();
    id_rs1_addr = a1; id_rf_rd1 = d1; id_rs2_addr = a2; id_rf_rd2 = d2;
    @(negedge clk);
  endtask

  task automatic set_later(input logic mw, input logic ml, input logic [AW-1:0] ma,
                           input logic [DW-1:0] md, input logic ww,
                           input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    mem_wen = mw; mem_is_load = ml; mem_rd_addr = ma; mem_alu_res = md;
    wb_wen = ww; wb_rd_addr = wa; wb_data = wd;
    #1;
  endtask

  task automatic t_reset();
    set_later(1, 0, 5'd0, 32'hDEAD_0001, 1, 5'd0, 32'hDEAD_0002);
    check("R10 reset a", ex_sel_a, ex_opnd_a, 2'b00, 32'h0);
    check("R10 reset b", ex_sel_b, ex_opnd_b, 2'b00, 32'h0);
  endtask

  task automatic t_no_match();
    load_ex(5'd3, 32'h1111_0003, 5'd4, 32'h2222_0004);
    set_later(1, 0, 5'd7, 32'hAAAA_0007, 1, 5'd8, 32'hBBBB_0008);
    check("R1 no match a", ex_sel_a, ex_opnd_a, 2'b00, 32'h1111_0003);
    check("R1 no match b", ex_sel_b, ex_opnd_b, 2'b00, 32'h2222_0004);
  endtask

  task automatic t_single();
    load_ex(5'd5, 32'h0000_0505, 5'd6, 32'h0000_0606);
    set_later(1, 0, 5'd5, 32'hC0DE_0005, 0, 5'd0, '0);
    check("R2 mem fwd a", ex_sel_a, ex_opnd_a, 2'b10, 32'hC0DE_0005);
    check("R9 b independent", ex_sel_b, ex_opnd_b, 2'b00, 32'h0000_0606);
    set_later(0, 0, 5'd0, '0, 1, 5'd6, 32'hFEED_0006);
    check("R3 wb fwd b", ex_sel_b, ex_opnd_b, 2'b01, 32'hFEED_0006);
    check("R9 a independent", ex_sel_a, ex_opnd_a, 2'b00, 32'h0000_0505);
    set_later(1, 0, 5'd5, 32'h1234_5678, 1, 5'd6, 32'h8765_4321);
    check("R9 a from mem", ex_sel_a, ex_opnd_a, 2'b10, 32'h1234_5678);
    check("R9 b from wb", ex_sel_b, ex_opnd_b, 2'b01, 32'h8765_4321);
  endtask

  task automatic t_double();
    // two writes to r9 in flight, then a read of r9
    load_ex(5'd9, 32'h0000_0009, 5'd9, 32'h0000_0009);
    set_later(1, 0, 5'd9, 32'h0000_0B0B, 1, 5'd9, 32'h0000_0A0A);
    check("R4 youngest wins a", ex_sel_a, ex_opnd_a, 2'b10, 32'h0000_0B0B);
    check("R4 youngest wins b", ex_sel_b, ex_opnd_b, 2'b10, 32'h0000_0B0B);
  endtask

  task automatic t_zero();
    load_ex(5'd0, 32'h0, 5'd0, 32'h0);
    set_later(1, 0, 5'd0, 32'hBAD0_BAD0, 1, 5'd0, 32'hBAD1_BAD1);
    check("R5 r0 a", ex_sel_a, ex_opnd_a, 2'b00, 32'h0);
    check("R5 r0 b", ex_sel_b, ex_opnd_b, 2'b00, 32'h0);
  endtask

  task automatic t_wen_off();
    load_ex(5'd12, 32'h0000_0C0C, 5'd13, 32'h0000_0D0D);
    set_later(0, 0, 5'd12, 32'hBAD2_0000, 0, 5'd13, 32'hBAD3_0000);
    check("R6 wen off a", ex_sel_a, ex_opnd_a, 2'b00, 32'h0000_0C0C);
    check("R6 wen off b", ex_sel_b, ex_opnd_b, 2'b00, 32'h0000_0D0D);
  endtask

  task automatic t_load();
    load_ex(5'd20, 32'h0000_1414, 5'd21, 32'h0000_1515);
    set_later(1, 1, 5'd20, 32'hADD0_0000, 1, 5'd20, 32'h0DA7_0014);
    check("R7 load skip to wb", ex_sel_a, ex_opnd_a, 2'b01, 32'h0DA7_0014);
    set_later(1, 1, 5'd21, 32'hADD0_0001, 0, 5'd0, '0);
    check("R7 load skip to rf", ex_sel_b, ex_opnd_b, 2'b00, 32'h0000_1515);
  endtask

  task automatic t_write_through();
    @(negedge clk);
    later_off();
    id_rs1_addr = 5'd9; id_rf_rd1 = 32'h0000_0001;
    id_rs2_addr = 5'd10; id_rf_rd2 = 32'h0000_0002;
    wb_wen = 1; wb_rd_addr = 5'd9; wb_data = 32'h0000_00AB;
    @(negedge clk);
    later_off();
    #1;
    check("R8 write-through a", ex_sel_a, ex_opnd_a, 2'b00, 32'h0000_00AB);
    check("R8 unrelated b", ex_sel_b, ex_opnd_b, 2'b00, 32'h0000_0002);
    @(negedge clk);
    id_rs1_addr = 5'd0; id_rf_rd1 = 32'h0;
    wb_wen = 1; wb_rd_addr = 5'd0; wb_data = 32'h0000_00CD;
    @(negedge clk);
    later_off();
    #1;
    check("R8 r0 no write-through", ex_sel_a, ex_opnd_a, 2'b00, 32'h0);
  endtask

  initial begin
    rst_n = 0;
    id_rs1_addr = '0; id_rs2_addr = '0; id_rf_rd1 = '0; id_rf_rd2 = '0;
    later_off();
    repeat (3) @(negedge clk);
    t_reset();
    later_off();
    @(negedge clk);
    rst_n = 1;
    t_no_match();
    t_single();
    t_double();
    t_zero();
    t_wen_off();
    t_load();
    t_write_through();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule